// File: doc/BRIEF.md
# Multi-Mode Bridge PWM Generator

This block produces a pulse-width modulated waveform with 10-bit duty resolution. It drives up to four output pins, labelled A to D, for a single load, a half bridge or a full bridge. The time base is an 8-bit period counter with two extra low-order fraction bits. It runs one step per clock. One period lasts (period + 1) × 4 clocks.

A single duty comparison forms one modulated signal. A steering stage routes that signal onto one, two or four pins, depending on the bridge mode. Each pin has its own output-enable, so a pin the current mode does not use can be released. Software writes the duty value over a one-cycle write strobe. That value, and the bridge mode, are only picked up at a period boundary, so a cycle is never cut short or re-steered halfway through. After an enable, the block stays silent until a complete period can start.

Top module: `bridge_pwm_top`

## Requirements
- R1: The 10-bit time base counts from 0 up to period × 4 + 3 and then returns to 0. One period therefore lasts (period + 1) × 4 clocks.
- R2: The modulated signal is active while the time base is below the shadowed duty value, and inactive from the count equal to that value until the period ends.
- R3: A duty value written with the write strobe is used only from the next period boundary onward. The period in progress keeps the earlier value.
- R4: A shadowed duty of 0 keeps the signal inactive for the whole period. A shadowed duty above period × 4 + 3 keeps it active for the whole period.
- R5: After enable rises, every output-enable stays low for period × 4 + 3 clocks. The first complete period then begins.
- R6: Mode 00 (single) drives only pin A (bit 0). The output-enable vector is 0001.
- R7: Mode 10 (half bridge) drives A with the signal and B (bit 1) with its complement. The output-enable vector is 0011.
- R8: Mode 01 (full bridge forward) holds A active, drives D (bit 3) with the signal, and holds B and C inactive. The output-enable vector is 1111.
- R9: Mode 11 (full bridge reverse) holds C (bit 2) active, drives B with the signal, and holds A and D inactive. The output-enable vector is 1111.
- R10: A change on the mode input takes effect only at the next period boundary.
- R11: Polarity bit 0 inverts pins A and C, and polarity bit 1 inverts pins B and D (1 = active-low). Inversion is applied after steering and takes effect at once.
- R12: While enable is low, all output-enables are 0 and all pin values are 0. A released pin always reads 0.
- R13: During and directly after reset, all output-enables and pin values are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the time base steps once per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| period | input | 8 | Period value of the coarse counter |
| duty_we | input | 1 | Write strobe for the duty value |
| duty_wdata | input | 10 | Duty value to be written |
| mode | input | 2 | Bridge mode: 00 single, 01 forward, 10 half, 11 reverse |
| pol | input | 2 | Polarity: bit 0 for A/C, bit 1 for B/D, 1 = active-low |
| pwm_out | output | 4 | Pin values, bit 0 = A to bit 3 = D |
| pwm_oe | output | 4 | Pin output-enables, same bit order |

## Verification
The bench builds the block with its default widths: an 8-bit coarse counter and 2 fraction bits. It uses period values 3 and 1, which give periods of only 16 and 8 clocks. At that length every clock of every period can be compared against the expected waveform. A duty of 20 against a 16-clock span reaches the always-active end, and a duty of 0 reaches the always-inactive end. Mode and duty changes placed both on and between boundaries exercise the shadow timing.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_FWD    = 2'b01,
      MODE_HALF   = 2'b10,
      MODE_REV    = 2'b11
   } bridge_mode_e;

   localparam int N_PINS = 4;
   localparam int POL_W  = 2;

endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
   parameter int CNT_W  = 8,
   parameter int FRAC_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [CNT_W-1:0]          period,
   output logic [CNT_W+FRAC_W-1:0]   tb,
   output logic                      wrap
);
   localparam int TB_W = CNT_W + FRAC_W;

   logic [TB_W-1:0] last_cnt;

   assign last_cnt = {period, {FRAC_W{1'b1}}};
   assign wrap     = en && (tb >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb <= '0;
      end else if (!en || wrap) begin
         tb <= '0;
      end else begin
         tb <= tb + 1'b1;
      end
   end
endmodule

// File: rtl/bpwm_shadow.sv
module bpwm_shadow #(
   parameter int TB_W = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      wrap,
   input  logic                      duty_we,
   input  logic [TB_W-1:0]           duty_wdata,
   input  bpwm_pkg::bridge_mode_e    mode_in,
   output logic [TB_W-1:0]           duty_sh,
   output bpwm_pkg::bridge_mode_e    mode_sh,
   output logic                      running
);
   logic [TB_W-1:0] duty_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_reg <= '0;
      end else if (duty_we) begin
         duty_reg <= duty_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_sh <= '0;
         mode_sh <= bpwm_pkg::MODE_SINGLE;
         running <= 1'b0;
      end else if (!en) begin
         running <= 1'b0;
      end else if (wrap) begin
         duty_sh <= duty_reg;
         mode_sh <= mode_in;
         running <= 1'b1;
      end
   end
endmodule

// File: rtl/bpwm_steer.sv
module bpwm_steer (
   input  logic                                  active,
   input  logic                                  live,
   input  bpwm_pkg::bridge_mode_e                mode_sh,
   input  logic [bpwm_pkg::POL_W-1:0]            pol,
   output logic [bpwm_pkg::N_PINS-1:0]           pin_out,
   output logic [bpwm_pkg::N_PINS-1:0]           pin_oe
);
   import bpwm_pkg::*;

   logic [N_PINS-1:0] lvl;
   logic [N_PINS-1:0] used;

   always_comb begin
      unique case (mode_sh)
         MODE_SINGLE: begin lvl = {3'b000, active};             used = 4'b0001; end
         MODE_HALF:   begin lvl = {2'b00, ~active, active};     used = 4'b0011; end
         MODE_FWD:    begin lvl = {active, 2'b00, 1'b1};        used = 4'b1111; end
         MODE_REV:    begin lvl = {1'b0, 1'b1, active, 1'b0};   used = 4'b1111; end
         default:     begin lvl = '0;                           used = '0;      end
      endcase
   end

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      localparam int PG = i % POL_W;
      assign pin_oe[i]  = used[i] & live;
      assign pin_out[i] = pin_oe[i] & (lvl[i] ^ pol[PG]);
   end
endmodule

// File: rtl/bridge_pwm_top.sv
module bridge_pwm_top #(
   parameter int CNT_W  = 8,
   parameter int FRAC_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [CNT_W-1:0]          period,
   input  logic                      duty_we,
   input  logic [CNT_W+FRAC_W-1:0]   duty_wdata,
   input  logic [1:0]                mode,
   input  logic [1:0]                pol,
   output logic [3:0]                pwm_out,
   output logic [3:0]                pwm_oe
);
   import bpwm_pkg::*;

   localparam int TB_W = CNT_W + FRAC_W;

   if (CNT_W < 2 || FRAC_W < 1) begin : g_bad_width
      $error("bridge_pwm_top: CNT_W must be >= 2 and FRAC_W >= 1");
   end
   if (N_PINS != 4 || POL_W != 2) begin : g_bad_pins
      $error("bridge_pwm_top: steering expects four pins and two polarity groups");
   end

   logic [TB_W-1:0] tb;
   logic            wrap;
   logic [TB_W-1:0] duty_sh;
   bridge_mode_e    mode_sh;
   logic            running;
   logic            live;
   logic            active;

   bpwm_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_tb (
      .clk(clk), .rst_n(rst_n), .en(en), .period(period), .tb(tb), .wrap(wrap)
   );

   bpwm_shadow #(.TB_W(TB_W)) i_sh (
      .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap),
      .duty_we(duty_we), .duty_wdata(duty_wdata),
      .mode_in(bridge_mode_e'(mode)),
      .duty_sh(duty_sh), .mode_sh(mode_sh), .running(running)
   );

   assign live   = running & en;
   assign active = tb < duty_sh;

   bpwm_steer i_st (
      .active(active), .live(live), .mode_sh(mode_sh), .pol(pol),
      .pin_out(pwm_out), .pin_oe(pwm_oe)
   );
endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic [1:0] pol,
   input logic [3:0] pwm_out,
   input logic [3:0] pwm_oe
);
   a_r12_disabled_released: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (pwm_oe == 4'b0000 && pwm_out == 4'b0000));

   a_r12_released_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out & ~pwm_oe) == 4'b0000);

   a_r6_oe_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_oe == 4'b0000 || pwm_oe == 4'b0001 || pwm_oe == 4'b0011 || pwm_oe == 4'b1111);

   a_r5_quiet_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |=> pwm_oe == 4'b0000);

   a_r7_half_complement: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_oe == 4'b0011 |-> ((pwm_out[0] ^ pol[0]) != (pwm_out[1] ^ pol[1])));

   a_r8_full_one_high_side: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_oe == 4'b1111 |-> ((pwm_out[0] ^ pol[0]) != (pwm_out[2] ^ pol[0])));
endmodule

bind bridge_pwm_top bpwm_checker i_chk (.*);

// File: tb/test_bridge_pwm_top.sv
module test_bridge_pwm_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       en;
   logic [7:0] period;
   logic       duty_we;
   logic [9:0] duty_wdata;
   logic [1:0] mode;
   logic [1:0] pol;
   logic [3:0] pwm_out;
   logic [3:0] pwm_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      logic [3:0] out;
      logic [3:0] oe;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bridge_pwm_top i_bridge_pwm_top (
      .clk(clk), .rst_n(rst_n), .en(en), .period(period),
      .duty_we(duty_we), .duty_wdata(duty_wdata),
      .mode(mode), .pol(pol), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );

   task automatic push_idle(int n, string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.out = 4'b0000; e.oe = 4'b0000; e.tag = tag;
         q.push_back(e);
      end
   endtask

   task automatic push_span(int d, int p, logic [1:0] m, logic [1:0] pl,
                            int i0, int i1, string tag);
      for (int i = i0; i <= i1; i++) begin
         logic       a;
         logic [3:0] lv;
         logic [3:0] us;
         exp_t       e;
         a = (i < d);
         case (m)
            2'b00:   begin lv = {3'b000, a};          us = 4'b0001; end
            2'b10:   begin lv = {2'b00, !a, a};       us = 4'b0011; end
            2'b01:   begin lv = {a, 2'b00, 1'b1};     us = 4'b1111; end
            default: begin lv = {1'b0, 1'b1, a, 1'b0}; us = 4'b1111; end
         endcase
         lv    = lv ^ {pl[1], pl[0], pl[1], pl[0]};
         e.out = lv & us;
         e.oe  = us;
         e.tag = tag;
         q.push_back(e);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_and_wait(logic [9:0] v, int n);
      duty_wdata = v;
      duty_we    = 1'b1;
      @(negedge clk);
      duty_we    = 1'b0;
      wait_n(n - 1);
   endtask

   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (pwm_out !== e.out || pwm_oe !== e.oe) begin
            bad++;
            $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b",
                     e.tag, pwm_out, pwm_oe, e.out, e.oe);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, pending=%0d expected=0", q.size());
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; period = 8'd3; duty_we = 1'b0;
      duty_wdata = '0; mode = 2'b00; pol = 2'b00;
      wait_n(2);
      push_idle(2, "R13 in reset");
      wait_n(2);
      rst_n = 1'b1;
      push_idle(2, "R13 after reset");
      wait_n(2);

      // single mode start-up, duty 6 of a 16-clock period
      period = 8'd3; mode = 2'b00; pol = 2'b00; en = 1'b1;
      push_idle(15, "R5 start-up");
      push_span(6, 3, 2'b00, 2'b00, 0, 15, "R1/R2/R6 period one");
      push_span(6, 3, 2'b00, 2'b00, 0, 15, "R1/R2/R6 period two");
      write_and_wait(10'd6, 47);

      // duty written on a boundary: old value for one more period
      push_span(6, 3, 2'b00, 2'b00, 0, 15, "R3 old duty");
      push_span(10, 3, 2'b00, 2'b00, 0, 15, "R3 new duty");
      write_and_wait(10'd10, 32);

      // mode change in mid period waits for the boundary
      push_span(10, 3, 2'b00, 2'b00, 0, 4, "R10 before change");
      wait_n(5);
      mode = 2'b10;
      push_span(10, 3, 2'b00, 2'b00, 5, 15, "R10 held single");
      push_span(10, 3, 2'b10, 2'b00, 0, 15, "R7/R10 half bridge");
      wait_n(27);

      // forward full bridge, polarity on A/C, then duty above span
      mode = 2'b01; pol = 2'b01;
      push_span(10, 3, 2'b01, 2'b01, 0, 15, "R8/R11 forward");
      push_span(20, 3, 2'b01, 2'b01, 0, 15, "R4/R8 full duty");
      write_and_wait(10'd20, 32);

      // reverse full bridge, both polarity bits, then zero duty
      mode = 2'b11; pol = 2'b11;
      push_span(20, 3, 2'b11, 2'b11, 0, 15, "R9/R11 reverse");
      push_span(0, 3, 2'b11, 2'b11, 0, 15, "R4/R9 zero duty");
      write_and_wait(10'd0, 32);

      // disable releases everything at once
      en = 1'b0;
      push_idle(3, "R12 disabled");
      wait_n(3);

      // restart with a short period
      period = 8'd1; mode = 2'b00; pol = 2'b00; en = 1'b1;
      push_idle(7, "R5 restart");
      push_span(3, 1, 2'b00, 2'b00, 0, 7, "R1/R2 short period one");
      push_span(3, 1, 2'b00, 2'b00, 0, 7, "R1/R2 short period two");
      write_and_wait(10'd3, 23);

      wait (q.size() == 0);
      wait_n(2);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule